// File: doc/BRIEF.md
# Health-Test Alert Failure Aggregator

This block sits behind a set of entropy health tests and turns their per-window verdicts into a decision about raising a recoverable alert. At the end of every test window the tests present one fail flag each, qualified by a window-done strobe. The block keeps a small saturating fail counter per test and a separate summary count of every failure reported. Once the summary count reaches a programmable threshold it pulses an alert output and an interrupt-status set output, then freezes all counts so software can inspect them.

A window in which no test fails clears every count, so only failures in consecutive windows build towards an alert. The threshold word carries a redundant inverted copy in its upper half. While the two halves disagree, alerting is blocked and a sticky configuration-alert status bit is held set. An explicit clear input zeroes all counts and re-arms detection. Every pin is a plain control or status signal: verdicts arrive as one-cycle qualified flags with no back-pressure, and the block accepts one window result per clock.

Top module: `ht_alert_agg`

## Requirements
- R1: After reset all counters and the summary count are zero, no alert or interrupt pulse is present, the configuration alert is low, and the threshold word is 0xFFFD0002, so the effective threshold is 2.
- R2: In a cycle with `win_done_i` high and at least one fail flag set, each flagged test's counter rises by one and the summary count rises by the number of flagged tests. Fail flags are ignored while `win_done_i` is low.
- R3: A cycle with `win_done_i` high and every fail flag low clears all counters and the summary count, unless the block is frozen.
- R4: When a failing window brings the summary count to a value at or above a nonzero, valid threshold, `alert_met_o` and `intr_set_o` are both high for exactly the one cycle after that window.
- R5: After an alert the block is frozen: further windows, passing or failing, leave all counts unchanged until `clear_i`.
- R6: A threshold value of zero disables alerting while counting continues.
- R7: Each per-test counter saturates at 15 and never wraps.
- R8: The summary count keeps adding failures after per-test counters saturate, and it saturates at 0xFFFF without wrapping.
- R9: When bits 31:16 of the threshold word are not the bitwise inverse of bits 15:0, `cfg_alert_o` is set from the next cycle. It stays set until a status write with `sts_wdata_i` = 0 is made while the word matches. A status write of 1 has no effect.
- R10: While the threshold word mismatches, no alert is raised, but counting goes on. Once the word is corrected, the next failing window is compared against it.
- R11: `clear_i` zeroes all counters and the summary count, takes precedence over a window in the same cycle, and re-arms alert detection.
- R12: Flag bit order for `fail_int_i` is: 0 repetition count, 1 repetition count symbol, 2 adaptive proportion high, 3 adaptive proportion low, 4 bucket, 5 Markov high, 6 Markov low. In `fail_ext_i`, bit 0 is the external high test and bit 1 is the external low test. Counter k sits at `cnt_o[4k+3:4k]`, with internal tests at k = 0..6 and external tests at k = 7..8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| win_done_i | input | 1 | Health-test window finished; qualifies the fail flags |
| fail_int_i | input | 7 | Fail flags of the internal test group |
| fail_ext_i | input | 2 | Fail flags of the external high and low tests |
| clear_i | input | 1 | Zero all counts and re-arm alert detection |
| thr_we_i | input | 1 | Write strobe for the threshold word |
| thr_wdata_i | input | 32 | Threshold word: inverted copy in 31:16, threshold in 15:0 |
| sts_we_i | input | 1 | Write strobe for the configuration-alert status bit |
| sts_wdata_i | input | 1 | Status write data; 0 clears the bit |
| cnt_o | output | 36 | Nine packed 4-bit per-test fail counters |
| sum_o | output | 16 | Summary failure count |
| alert_met_o | output | 1 | One-cycle recoverable-alert pulse |
| intr_set_o | output | 1 | One-cycle health-test-failed interrupt status set |
| cfg_alert_o | output | 1 | Sticky threshold-mismatch status |

## Verification
The hardest state to reach is summary-count saturation. It needs more than seven thousand consecutive failing windows with no alert freezing the counts. The stimulus first programs a valid zero threshold to disable alerting, then holds the window strobe and all nine fail flags high for 7282 cycles. This drives every per-test counter into saturation and pushes the summary to 0xFFFF. A second hard case is correcting a mismatched threshold after counts have built up while alerting was blocked. It is reached by writing a bad word, running failing windows, and then restoring a good word before one more failing window.

// File: rtl/ht_alert_pkg.sv
package ht_alert_pkg;
  localparam int unsigned N_INT   = 7;
  localparam int unsigned N_EXT   = 2;
  localparam int unsigned CNT_W   = 4;
  localparam int unsigned SUM_W   = 16;
  localparam int unsigned THR_W   = 16;
  localparam logic [15:0] THR_DEF = 16'd2;
endpackage

// File: rtl/ht_sat_cnt.sv
module ht_sat_cnt #(
  parameter int unsigned W      = 4,
  parameter int unsigned STEP_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              zero_i,
  input  logic              add_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [W-1:0]      nxt_o,
  output logic [W-1:0]      cnt_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   wide;

  always_comb begin
    wide = {1'b0, cnt_q} + {{(W + 1 - STEP_W){1'b0}}, step_i};
    if (zero_i)     nxt_o = '0;
    else if (add_i) nxt_o = wide[W] ? {W{1'b1}} : wide[W-1:0];
    else            nxt_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ht_thr_guard.sv
module ht_thr_guard #(
  parameter int unsigned       THR_W   = 16,
  parameter logic [THR_W-1:0]  THR_DEF = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [2*THR_W-1:0] wdata_i,
  input  logic               sts_we_i,
  input  logic               sts_wdata_i,
  output logic [THR_W-1:0]   thr_o,
  output logic               thr_ok_o,
  output logic               cfg_alert_o
);
  localparam logic [2*THR_W-1:0] WORD_RST = {~THR_DEF, THR_DEF};

  logic [2*THR_W-1:0] word_q;
  logic               sticky_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= WORD_RST;
    else if (we_i) word_q <= wdata_i;
  end

  assign thr_o    = word_q[THR_W-1:0];
  assign thr_ok_o = (word_q[2*THR_W-1:THR_W] == ~word_q[THR_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      sticky_q <= 1'b0;
    else if (!thr_ok_o)               sticky_q <= 1'b1;
    else if (sts_we_i && !sts_wdata_i) sticky_q <= 1'b0;
  end

  assign cfg_alert_o = sticky_q;
endmodule

// File: rtl/ht_alert_agg.sv
module ht_alert_agg
  import ht_alert_pkg::*;
#(
  parameter int unsigned NI = N_INT,
  parameter int unsigned NE = N_EXT,
  parameter int unsigned CW = CNT_W,
  parameter int unsigned SW = SUM_W,
  parameter int unsigned TW = THR_W,
  localparam int unsigned NT = NI + NE,
  localparam int unsigned PW = $clog2(NT + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            win_done_i,
  input  logic [NI-1:0]   fail_int_i,
  input  logic [NE-1:0]   fail_ext_i,
  input  logic            clear_i,
  input  logic            thr_we_i,
  input  logic [2*TW-1:0] thr_wdata_i,
  input  logic            sts_we_i,
  input  logic            sts_wdata_i,
  output logic [NT*CW-1:0] cnt_o,
  output logic [SW-1:0]   sum_o,
  output logic            alert_met_o,
  output logic            intr_set_o,
  output logic            cfg_alert_o
);
  logic [NT-1:0] fail_all;
  logic [PW-1:0] n_fail;
  logic          any_fail, win_eff, zero_all, fire;
  logic          frozen_q, alert_q, intr_q;
  logic [TW-1:0] thr;
  logic          thr_ok;
  logic [SW-1:0] sum_nxt;

  assign fail_all = {fail_ext_i, fail_int_i};
  assign any_fail = |fail_all;
  assign win_eff  = win_done_i && !frozen_q && !clear_i;
  assign zero_all = clear_i || (win_done_i && !frozen_q && !any_fail);

  always_comb begin
    n_fail = '0;
    for (int k = 0; k < NT; k++) n_fail = n_fail + PW'(fail_all[k]);
  end

  for (genvar k = 0; k < NT; k++) begin : g_test
    logic [CW-1:0] unused_nxt;
    ht_sat_cnt #(.W(CW), .STEP_W(1)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .zero_i (zero_all),
      .add_i  (win_eff && fail_all[k]),
      .step_i (1'b1),
      .nxt_o  (unused_nxt),
      .cnt_o  (cnt_o[k*CW +: CW])
    );
  end

  ht_sat_cnt #(.W(SW), .STEP_W(PW)) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .zero_i (zero_all),
    .add_i  (win_eff && any_fail),
    .step_i (n_fail),
    .nxt_o  (sum_nxt),
    .cnt_o  (sum_o)
  );

  ht_thr_guard #(.THR_W(TW), .THR_DEF(TW'(THR_DEF))) u_thr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (thr_we_i),
    .wdata_i     (thr_wdata_i),
    .sts_we_i    (sts_we_i),
    .sts_wdata_i (sts_wdata_i),
    .thr_o       (thr),
    .thr_ok_o    (thr_ok),
    .cfg_alert_o (cfg_alert_o)
  );

  assign fire = win_eff && any_fail && thr_ok && (thr != '0) &&
                (SW'(sum_nxt) >= SW'(thr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q <= 1'b0;
      alert_q  <= 1'b0;
      intr_q   <= 1'b0;
    end else begin
      alert_q <= fire;
      intr_q  <= fire;
      if (clear_i)   frozen_q <= 1'b0;
      else if (fire) frozen_q <= 1'b1;
    end
  end

  assign alert_met_o = alert_q;
  assign intr_set_o  = intr_q;
endmodule

// File: rtl/ht_alert_agg_chk.sv
module ht_alert_agg_chk #(
  parameter int unsigned NT = 9,
  parameter int unsigned CW = 4,
  parameter int unsigned SW = 16,
  parameter int unsigned TW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            win_done_i,
  input logic [NT-1:0]   fail_all,
  input logic            clear_i,
  input logic [NT*CW-1:0] cnt_o,
  input logic [SW-1:0]   sum_o,
  input logic            alert_met_o,
  input logic            intr_set_o,
  input logic            cfg_alert_o,
  input logic            thr_ok,
  input logic [TW-1:0]   thr,
  input logic            frozen_q
);
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_met_o |=> !alert_met_o);

  a_r4_intr_with_alert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_met_o |-> intr_set_o);

  a_r5_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_q && !clear_i) |=> ($stable(cnt_o) && $stable(sum_o)));

  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !(win_done_i && fail_all == '0)) |=> (sum_o >= $past(sum_o)));

  a_r9_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thr_ok |=> cfg_alert_o);

  a_r10_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_met_o |-> ($past(thr_ok) && $past(thr) != '0));

  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_o == '0 && sum_o == '0 && !alert_met_o));
endmodule

bind ht_alert_agg ht_alert_agg_chk #(.NT(NT), .CW(CW), .SW(SW), .TW(TW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .win_done_i  (win_done_i),
  .fail_all    (fail_all),
  .clear_i     (clear_i),
  .cnt_o       (cnt_o),
  .sum_o       (sum_o),
  .alert_met_o (alert_met_o),
  .intr_set_o  (intr_set_o),
  .cfg_alert_o (cfg_alert_o),
  .thr_ok      (thr_ok),
  .thr         (thr),
  .frozen_q    (frozen_q)
);

// File: tb/ht_alert_agg_tb_top.sv
`timescale 1ns/1ps
module ht_alert_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win = 1'b0;
  logic [6:0]  fi = '0;
  logic [1:0]  fe = '0;
  logic        clr = 1'b0;
  logic        twe = 1'b0;
  logic [31:0] twd = '0;
  logic        swe = 1'b0;
  logic        swd = 1'b0;
  logic [35:0] cnt;
  logic [15:0] sum;
  logic        alert, intr, cfga;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ht_alert_agg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .win_done_i(win), .fail_int_i(fi),
    .fail_ext_i(fe), .clear_i(clr), .thr_we_i(twe), .thr_wdata_i(twd),
    .sts_we_i(swe), .sts_wdata_i(swd), .cnt_o(cnt), .sum_o(sum),
    .alert_met_o(alert), .intr_set_o(intr), .cfg_alert_o(cfga)
  );

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] c(input int k);
    return cnt[4*k +: 4];
  endfunction

  task automatic window(input logic [6:0] i7, input logic [1:0] e2);
    @(negedge clk); win = 1'b1; fi = i7; fe = e2;
    @(posedge clk);
    @(negedge clk); win = 1'b0; fi = '0; fe = '0;
  endtask

  task automatic thr_write(input logic [31:0] w);
    @(negedge clk); twe = 1'b1; twd = w;
    @(posedge clk);
    @(negedge clk); twe = 1'b0;
  endtask

  task automatic sts_write(input logic b);
    @(negedge clk); swe = 1'b1; swd = b;
    @(posedge clk);
    @(negedge clk); swe = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(posedge clk);
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 counters", cnt, 36'h0);
    check("R1 sum", {20'h0, sum}, 36'h0);
    check("R1 alert", {35'h0, alert}, 36'h0);
    check("R1 cfg_alert", {35'h0, cfga}, 36'h0);
  endtask

  task automatic t_count_and_pass();
    @(negedge clk); fi = 7'h7F; fe = 2'b11;
    @(negedge clk); fi = '0; fe = '0;
    check("R2 flags ignored without strobe", {20'h0, sum}, 36'h0);
    window(7'b0000100, 2'b00);
    check("R2 R12 adaptive hi counter", {32'h0, c(2)}, 36'h1);
    check("R2 sum one", {20'h0, sum}, 36'h1);
    window(7'b0000000, 2'b00);
    check("R3 pass clears counters", cnt, 36'h0);
    check("R3 pass clears sum", {20'h0, sum}, 36'h0);
  endtask

  task automatic t_alert_freeze();
    window(7'b0000001, 2'b00);
    check("R1 R4 no alert below default 2", {35'h0, alert}, 36'h0);
    window(7'b0000000, 2'b10);
    check("R12 external low is counter 8", {32'h0, c(8)}, 36'h1);
    check("R4 alert pulse at threshold", {34'h0, alert, intr}, 36'h3);
    @(negedge clk);
    check("R4 alert one cycle", {34'h0, alert, intr}, 36'h0);
    window(7'b0000000, 2'b00);
    check("R5 pass window frozen", {20'h0, sum}, 36'h2);
    window(7'h7F, 2'b11);
    check("R5 fail window frozen", {20'h0, sum}, 36'h2);
    check("R5 alert not repeated", {35'h0, alert}, 36'h0);
    do_clear();
    check("R11 clear zeroes", {cnt[19:0], sum}, 36'h0);
    window(7'b0001011, 2'b00);
    check("R4 R11 rearmed jump past threshold", {34'h0, alert, intr}, 36'h3);
    check("R2 sum by three", {20'h0, sum}, 36'h3);
    do_clear();
  endtask

  task automatic t_saturate();
    thr_write(32'hFFFF_0000);
    @(negedge clk); win = 1'b1; fi = 7'h7F; fe = 2'b11;
    repeat (7282) @(posedge clk);
    @(negedge clk); win = 1'b0; fi = '0; fe = '0;
    check("R7 all counters at 15", cnt, 36'hF_FFFF_FFFF);
    check("R8 sum saturated", {20'h0, sum}, 36'hFFFF);
    check("R6 zero threshold no alert", {35'h0, alert}, 36'h0);
    window(7'h7F, 2'b11);
    check("R8 sum stays saturated", {20'h0, sum}, 36'hFFFF);
    do_clear();
    thr_write(32'hFFFD_0002);
  endtask

  task automatic t_mismatch();
    thr_write(32'h1234_0002);
    @(negedge clk);
    check("R9 cfg alert set", {35'h0, cfga}, 36'h1);
    window(7'b0000001, 2'b00);
    window(7'b0000001, 2'b00);
    check("R10 blocked no alert", {35'h0, alert}, 36'h0);
    check("R10 counting continues", {32'h0, c(0)}, 36'h2);
    sts_write(1'b0);
    check("R9 clear refused while mismatched", {35'h0, cfga}, 36'h1);
    thr_write(32'hFFFD_0002);
    window(7'b0000001, 2'b00);
    check("R10 alert after correction", {35'h0, alert}, 36'h1);
    sts_write(1'b1);
    check("R9 write one no effect", {35'h0, cfga}, 36'h1);
    sts_write(1'b0);
    check("R9 write zero clears", {35'h0, cfga}, 36'h0);
    do_clear();
  endtask

  task automatic t_clear_priority();
    window(7'b1000000, 2'b00);
    @(negedge clk); clr = 1'b1; win = 1'b1; fi = 7'h7F; fe = 2'b11;
    @(posedge clk);
    @(negedge clk); clr = 1'b0; win = 1'b0; fi = '0; fe = '0;
    check("R11 clear beats window", {20'h0, sum}, 36'h0);
    check("R11 no alert on cleared window", {35'h0, alert}, 36'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_and_pass();
    t_alert_freeze();
    t_saturate();
    t_mismatch();
    t_clear_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule